// File: doc/BRIEF.md
# Multi-Mode Power State Controller

This block steers a chip between its running state and five reduced-power states. Software places a 3-bit target code on `mode_sel`. A pulse on `cpu_standby` then starts entry. The target code selects a gating profile, and two configuration bits adjust it. The controller applies the profile in three timed steps. First it isolates the affected domains, then it stops their clocks, and last it opens their power switches. The controller then waits in the low state until `wake_evt` arrives.

Exit runs the same three steps in reverse. Power comes back first, and the controller waits for `pwr_good` or a timeout. Clocks are then re-enabled and isolation is dropped before the controller reports Normal again. The external regulator is shut off only in the deepest state. Leaving that state ends with a one-cycle wakeup reset pulse, so the chip restarts as from power-on. Every other state resumes without a reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `mode_sel` codes are 0 Normal, 1 Idle, 2 Deep-idle, 3 Stop, 4 Deep-stop, 5 Sleep. A request is sampled when `cpu_standby` is high in Normal. Codes 6 and 7 are treated as Normal and set `mode_err`; a valid code clears `mode_err`. A request whose effective target is Normal changes no output other than `mode_err`. `cur_mode` reports the active target, and 0 when in Normal; after reset it is 0 and `mode_err` is 0.
- R2: In Idle only `cpu_clk_en` is deasserted. All isolation, power and regulator outputs and `sys_clk_en` stay active.
- R3: In Deep-idle the CPU domain is isolated and power-gated and `cpu_clk_en` is low. The general domain is gated only when `gen_keep` is 0. The audio and top domains stay powered, and `sys_clk_en` stays high.
- R4: In Stop both clock enables are low, and no domain is isolated or power-gated.
- R5: In Deep-stop both clocks are off, and the CPU, general and audio domains are isolated and power-gated. The top domain is gated only when `top_keep` is 0. `reg_en` stays high.
- R6: In Sleep all four domains are isolated and power-gated, both clocks are off, and `reg_en` is low.
- R7: Entry first asserts isolation, in the cycle after the request edge. Clocks are gated N cycles later, and power is gated N cycles after that. The low state is reached N cycles after power gating. N is `step_len`, with 0 meaning 4. Power is never off for a domain that is not isolated.
- R8: On the first wakeup edge in the low state all power enables and `reg_en` return high, while clocks stay gated. Clocks come back on the edge that sees `pwr_good` high, or PG_TIMEOUT edges after the power restore, whichever is first.
- R9: Isolation is released N cycles after the clocks return, and `cur_mode` returns to 0 N cycles after that.
- R10: `wake_rst` is high for exactly one cycle, in the first Normal cycle after leaving Sleep. It is never high after leaving any other state.
- R11: A wakeup during entry is held. Exit then starts on the first edge after the low state is reached, with no new wakeup required.
- R12: `wake_evt` in Normal has no effect, and `cpu_standby` outside Normal has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Target state code |
| gen_keep | input | 1 | Keep general domain powered in Deep-idle |
| top_keep | input | 1 | Keep top domain powered in Deep-stop |
| step_len | input | SW | Cycles per sequencing step, 0 selects 4 |
| cpu_standby | input | 1 | Starts entry into the selected state |
| wake_evt | input | 1 | Wakeup event |
| pwr_good | input | 1 | Restored supply is stable |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | Clock enable for the rest of the chip |
| iso_cpu | output | 1 | CPU domain isolation |
| iso_gen | output | 1 | General domain isolation |
| iso_aud | output | 1 | Audio domain isolation |
| iso_top | output | 1 | Top domain isolation |
| pwr_en_cpu | output | 1 | CPU power switch enable |
| pwr_en_gen | output | 1 | General domain power switch enable |
| pwr_en_aud | output | 1 | Audio domain power switch enable |
| pwr_en_top | output | 1 | Top domain power switch enable |
| reg_en | output | 1 | External regulator enable |
| wake_rst | output | 1 | Wakeup reset pulse |
| cur_mode | output | 3 | Active target state code |
| mode_err | output | 1 | Last request used an unused code |

## Verification
The hardest case to reach is a wakeup that lands during entry. The pending flag only matters if the controller still cuts power and then leaves the low state on the very next edge. To reach it, the stimulus pulses `wake_evt` in the first isolation cycle, at random step lengths, and checks at the ports that power is gated for one cycle and then restored. A second difficult path is the power-good timeout. It is reached by holding `pwr_good` low for a random delay that sometimes exceeds the timeout. A stray `cpu_standby` is also issued while the controller sits in the low state.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    M_NORMAL = 3'd0,
    M_IDLE   = 3'd1,
    M_DIDLE  = 3'd2,
    M_STOP   = 3'd3,
    M_DSTOP  = 3'd4,
    M_SLEEP  = 3'd5
  } pmode_e;

  typedef enum logic [2:0] {
    PH_RUN, PH_E_ISO, PH_E_CLK, PH_E_PWR,
    PH_LOW, PH_X_PWR, PH_X_CLK, PH_X_ISO
  } phase_e;

  localparam int NDOM    = 4;
  localparam int DOM_CPU = 0;
  localparam int DOM_GEN = 1;
  localparam int DOM_AUD = 2;
  localparam int DOM_TOP = 3;

  typedef struct packed {
    logic            cpu_clk_off;
    logic            sys_clk_off;
    logic [NDOM-1:0] dom_off;
    logic            reg_off;
  } gate_prof_t;
endpackage

// File: rtl/pmc_profile.sv
module pmc_profile
  import pmc_pkg::*;
(
  input  logic [2:0]  mode_raw,
  input  logic        gen_keep,
  input  logic        top_keep,
  output pmode_e      mode,
  output logic        invalid,
  output gate_prof_t  prof
);
  always_comb begin
    invalid = (mode_raw > 3'd5);
    mode    = invalid ? M_NORMAL : pmode_e'(mode_raw);
    prof    = '0;
    case (mode)
      M_IDLE: begin
        prof.cpu_clk_off = 1'b1;
      end
      M_DIDLE: begin
        prof.cpu_clk_off      = 1'b1;
        prof.dom_off[DOM_CPU] = 1'b1;
        prof.dom_off[DOM_GEN] = ~gen_keep;
      end
      M_STOP: begin
        prof.cpu_clk_off = 1'b1;
        prof.sys_clk_off = 1'b1;
      end
      M_DSTOP: begin
        prof.cpu_clk_off      = 1'b1;
        prof.sys_clk_off      = 1'b1;
        prof.dom_off[DOM_CPU] = 1'b1;
        prof.dom_off[DOM_GEN] = 1'b1;
        prof.dom_off[DOM_AUD] = 1'b1;
        prof.dom_off[DOM_TOP] = ~top_keep;
      end
      M_SLEEP: begin
        prof.cpu_clk_off = 1'b1;
        prof.sys_clk_off = 1'b1;
        prof.dom_off     = '1;
        prof.reg_off     = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmc_timer.sv
module pmc_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == '0);

  always_comb begin
    if (load)      cnt_d = load_val;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: an expired count stays expired until reloaded
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done);
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int SW         = 4,
  parameter int CW         = 5,
  parameter int DEF_STEP   = 4,
  parameter int PG_TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  pmode_e        req_mode,
  input  logic          req_invalid,
  input  gate_prof_t    req_prof,
  input  logic [SW-1:0] step_len,
  input  logic          wake_evt,
  input  logic          pwr_good,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output gate_prof_t    prof_q,
  output logic          st_iso,
  output logic          st_clk,
  output logic          st_pwr,
  output pmode_e        mode_q,
  output logic          err_q,
  output logic          wake_rst
);
  phase_e     phase_q, phase_d;
  gate_prof_t prof_d;
  pmode_e     mode_d;
  logic       iso_q, iso_d, clk_q, clk_d, pwr_q, pwr_d;
  logic       err_d, pend_q, pend_d, wrst_q, wrst_d;
  logic [CW-1:0] step_m1;

  assign step_m1 = ((step_len == '0) ? CW'(DEF_STEP) : CW'(step_len)) - 1'b1;

  always_comb begin
    phase_d  = phase_q;
    prof_d   = prof_q;
    mode_d   = mode_q;
    iso_d    = iso_q;
    clk_d    = clk_q;
    pwr_d    = pwr_q;
    err_d    = err_q;
    pend_d   = pend_q;
    wrst_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = step_m1;
    case (phase_q)
      PH_RUN: begin
        pend_d = 1'b0;
        if (req) begin
          err_d = req_invalid;
          if (req_mode != M_NORMAL) begin
            phase_d  = PH_E_ISO;
            prof_d   = req_prof;
            mode_d   = req_mode;
            iso_d    = 1'b1;
            tmr_load = 1'b1;
          end
        end
      end
      PH_E_ISO: begin
        pend_d = pend_q | wake_evt;
        if (tmr_done) begin
          phase_d  = PH_E_CLK;
          clk_d    = 1'b1;
          tmr_load = 1'b1;
        end
      end
      PH_E_CLK: begin
        pend_d = pend_q | wake_evt;
        if (tmr_done) begin
          phase_d  = PH_E_PWR;
          pwr_d    = 1'b1;
          tmr_load = 1'b1;
        end
      end
      PH_E_PWR: begin
        pend_d = pend_q | wake_evt;
        if (tmr_done) phase_d = PH_LOW;
      end
      PH_LOW: begin
        if (wake_evt || pend_q) begin
          phase_d  = PH_X_PWR;
          pwr_d    = 1'b0;
          pend_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CW'(PG_TIMEOUT - 1);
        end
      end
      PH_X_PWR: begin
        if (pwr_good || tmr_done) begin
          phase_d  = PH_X_CLK;
          clk_d    = 1'b0;
          tmr_load = 1'b1;
        end
      end
      PH_X_CLK: begin
        if (tmr_done) begin
          phase_d  = PH_X_ISO;
          iso_d    = 1'b0;
          tmr_load = 1'b1;
        end
      end
      PH_X_ISO: begin
        if (tmr_done) begin
          phase_d = PH_RUN;
          wrst_d  = (mode_q == M_SLEEP);
          mode_d  = M_NORMAL;
        end
      end
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      prof_q  <= '0;
      mode_q  <= M_NORMAL;
      iso_q   <= 1'b0;
      clk_q   <= 1'b0;
      pwr_q   <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      wrst_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      prof_q  <= prof_d;
      mode_q  <= mode_d;
      iso_q   <= iso_d;
      clk_q   <= clk_d;
      pwr_q   <= pwr_d;
      err_q   <= err_d;
      pend_q  <= pend_d;
      wrst_q  <= wrst_d;
    end
  end

  assign st_iso   = iso_q;
  assign st_clk   = clk_q;
  assign st_pwr   = pwr_q;
  assign wake_rst = wrst_q;

  // R7: clock gating only under isolation, power gating only with clocks stopped
  p_clk_needs_iso_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q |-> iso_q);
  p_pwr_needs_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q |-> clk_q);
  // R10: wakeup reset is a single cycle and follows a Sleep exit
  p_wake_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrst_q |=> !wrst_q);
  p_wake_rst_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrst_q |-> (mode_q == M_NORMAL) && ($past(mode_q) == M_SLEEP));
  // R11: held wakeup leaves the low state on the next edge
  p_exit_prompt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW && pend_q) |=> (phase_q == PH_X_PWR));
  // R12: latched profile cannot change outside Normal
  p_busy_ignores_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RUN) |=> $stable(prof_q));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SW         = 4,
  parameter int DEF_STEP   = 4,
  parameter int PG_TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic          gen_keep,
  input  logic          top_keep,
  input  logic [SW-1:0] step_len,
  input  logic          cpu_standby,
  input  logic          wake_evt,
  input  logic          pwr_good,
  output logic          cpu_clk_en,
  output logic          sys_clk_en,
  output logic          iso_cpu,
  output logic          iso_gen,
  output logic          iso_aud,
  output logic          iso_top,
  output logic          pwr_en_cpu,
  output logic          pwr_en_gen,
  output logic          pwr_en_aud,
  output logic          pwr_en_top,
  output logic          reg_en,
  output logic          wake_rst,
  output logic [2:0]    cur_mode,
  output logic          mode_err
);
  localparam int PW = $clog2(PG_TIMEOUT + 1);
  localparam int CW = (SW > PW) ? SW : PW;

  pmode_e          req_mode, mode_q;
  logic            req_invalid;
  gate_prof_t      req_prof, prof_q;
  logic            tmr_load, tmr_done;
  logic [CW-1:0]   tmr_val;
  logic            st_iso, st_clk, st_pwr;
  logic [NDOM-1:0] iso_v, pwr_v;

  pmc_profile u_profile (
    .mode_raw (mode_sel),
    .gen_keep (gen_keep),
    .top_keep (top_keep),
    .mode     (req_mode),
    .invalid  (req_invalid),
    .prof     (req_prof)
  );

  pmc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  pmc_seq #(
    .SW(SW), .CW(CW), .DEF_STEP(DEF_STEP), .PG_TIMEOUT(PG_TIMEOUT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (cpu_standby),
    .req_mode    (req_mode),
    .req_invalid (req_invalid),
    .req_prof    (req_prof),
    .step_len    (step_len),
    .wake_evt    (wake_evt),
    .pwr_good    (pwr_good),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .prof_q      (prof_q),
    .st_iso      (st_iso),
    .st_clk      (st_clk),
    .st_pwr      (st_pwr),
    .mode_q      (mode_q),
    .err_q       (mode_err),
    .wake_rst    (wake_rst)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    assign iso_v[d] = st_iso & prof_q.dom_off[d];
    assign pwr_v[d] = ~(st_pwr & prof_q.dom_off[d]);
    // R7: a domain is isolated whenever its switch is open
    p_iso_cover_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_v[d] |-> iso_v[d]);
  end

  assign cpu_clk_en = ~(st_clk & prof_q.cpu_clk_off);
  assign sys_clk_en = ~(st_clk & prof_q.sys_clk_off);
  assign reg_en     = ~(st_pwr & prof_q.reg_off);
  assign iso_cpu    = iso_v[DOM_CPU];
  assign iso_gen    = iso_v[DOM_GEN];
  assign iso_aud    = iso_v[DOM_AUD];
  assign iso_top    = iso_v[DOM_TOP];
  assign pwr_en_cpu = pwr_v[DOM_CPU];
  assign pwr_en_gen = pwr_v[DOM_GEN];
  assign pwr_en_aud = pwr_v[DOM_AUD];
  assign pwr_en_top = pwr_v[DOM_TOP];
  assign cur_mode   = mode_q;

  // R6: regulator off only with every domain switched off
  p_reg_off_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> (pwr_v == '0));
  // R3: general domain is gated only together with the CPU
  p_gen_with_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_gen |-> !pwr_en_cpu);
  // R5: audio is gated only when the system clock is stopped
  p_aud_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_aud |-> !sys_clk_en);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SW         = 4;
  localparam int PGT        = 16;

  logic clk, rst_n;
  logic [2:0] mode_sel;
  logic gen_keep, top_keep, cpu_standby, wake_evt, pwr_good;
  logic [SW-1:0] step_len;
  logic cpu_clk_en, sys_clk_en, iso_cpu, iso_gen, iso_aud, iso_top;
  logic pwr_en_cpu, pwr_en_gen, pwr_en_aud, pwr_en_top, reg_en, wake_rst, mode_err;
  logic [2:0] cur_mode;

  int n_chk = 0;
  int n_fail = 0;

  pwr_mode_ctrl #(.SW(SW), .DEF_STEP(4), .PG_TIMEOUT(PGT)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .gen_keep(gen_keep),
    .top_keep(top_keep), .step_len(step_len), .cpu_standby(cpu_standby),
    .wake_evt(wake_evt), .pwr_good(pwr_good), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .iso_cpu(iso_cpu), .iso_gen(iso_gen),
    .iso_aud(iso_aud), .iso_top(iso_top), .pwr_en_cpu(pwr_en_cpu),
    .pwr_en_gen(pwr_en_gen), .pwr_en_aud(pwr_en_aud), .pwr_en_top(pwr_en_top),
    .reg_en(reg_en), .wake_rst(wake_rst), .cur_mode(cur_mode), .mode_err(mode_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [3:0] iso_now();
    return {iso_top, iso_aud, iso_gen, iso_cpu};
  endfunction
  function automatic logic [3:0] pwr_now();
    return {pwr_en_top, pwr_en_aud, pwr_en_gen, pwr_en_cpu};
  endfunction
  function automatic logic [1:0] clk_now();
    return {sys_clk_en, cpu_clk_en};
  endfunction

  // expected gating from the requirements: bit0 cpu, 1 gen, 2 aud, 3 top
  function automatic logic [3:0] exp_dom(int m, logic gk, logic tk);
    case (m)
      2: return {1'b0, 1'b0, ~gk, 1'b1};
      4: return {~tk, 1'b1, 1'b1, 1'b1};
      5: return 4'hF;
      default: return 4'h0;
    endcase
  endfunction
  function automatic logic [1:0] exp_clk_off(int m);
    if (m == 1 || m == 2) return 2'b01;
    if (m >= 3 && m <= 5) return 2'b11;
    return 2'b00;
  endfunction
  function automatic string req_of(int m);
    case (m)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                     input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_mode(input int m, input logic gk, input logic tk,
                          input int sl, input int pgd, input logic early);
    int n;
    int e;
    logic [3:0] dom;
    logic [1:0] coff;
    string rq;
    n    = (sl == 0) ? 4 : sl;
    dom  = exp_dom(m, gk, tk);
    coff = exp_clk_off(m);
    rq   = req_of(m);
    mode_sel = 3'(m); gen_keep = gk; top_keep = tk; step_len = SW'(sl);
    cpu_standby = 1'b1;
    step();
    cpu_standby = 1'b0;
    if (m == 0 || m > 5) begin
      chk({4'h0, iso_now()}, 8'h0, "R1", "iso after Normal/invalid request");
      chk({4'h0, pwr_now()}, 8'hF, "R1", "pwr after Normal/invalid request");
      chk({6'h0, clk_now()}, 8'h3, "R1", "clk after Normal/invalid request");
      chk({5'h0, cur_mode}, 8'h0, "R1", "cur_mode stays Normal");
      chk({7'h0, mode_err}, {7'h0, (m > 5) ? 1'b1 : 1'b0}, "R1", "mode_err");
      return;
    end
    chk({7'h0, mode_err}, 8'h0, "R1", "mode_err cleared by valid code");
    chk({4'h0, iso_now()}, {4'h0, dom}, "R7", "isolation first");
    chk({6'h0, clk_now()}, 8'h3, "R7", "clocks still on during isolation");
    if (early) wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    repeat (n - 1) step();
    chk({6'h0, clk_now()}, {6'h0, ~coff}, rq, "clocks gated after N");
    chk({4'h0, pwr_now()}, 8'hF, "R7", "power still on after clock gating");
    repeat (n) step();
    chk({4'h0, pwr_now()}, {4'h0, ~dom}, rq, "power profile");
    chk({7'h0, reg_en}, {7'h0, (m == 5) ? 1'b0 : 1'b1}, rq, "regulator enable");
    repeat (n) step();
    chk({5'h0, cur_mode}, 8'(m), rq, "cur_mode in low state");
    if (early) begin
      chk({4'h0, pwr_now()}, {4'h0, ~dom}, "R11", "power gated before held wake");
      step();
      chk({4'h0, pwr_now()}, 8'hF, "R11", "held wake restores power at once");
    end else begin
      mode_sel = 3'd1; cpu_standby = 1'b1;
      step();
      cpu_standby = 1'b0;
      chk({5'h0, cur_mode}, 8'(m), "R12", "standby ignored in low state");
      chk({4'h0, pwr_now()}, {4'h0, ~dom}, "R12", "power unchanged by stray standby");
      wake_evt = 1'b1;
      step();
      wake_evt = 1'b0;
    end
    chk({4'h0, pwr_now()}, 8'hF, "R8", "power restored first");
    chk({7'h0, reg_en}, 8'h1, "R8", "regulator restored");
    chk({6'h0, clk_now()}, {6'h0, ~coff}, "R8", "clocks held during power restore");
    e = (pgd + 1 < PGT) ? pgd + 1 : PGT;
    for (int j = 1; j <= e; j++) begin
      pwr_good = (j > pgd);
      step();
      if (j < e) chk({6'h0, clk_now()}, {6'h0, ~coff}, "R8", "clocks wait for power good");
    end
    pwr_good = 1'b0;
    chk({6'h0, clk_now()}, 8'h3, "R8", "clocks back after power good or timeout");
    chk({4'h0, iso_now()}, {4'h0, dom}, "R9", "isolation held after clock restore");
    repeat (n) step();
    chk({4'h0, iso_now()}, 8'h0, "R9", "isolation released");
    chk({5'h0, cur_mode}, 8'(m), "R9", "still exiting");
    repeat (n) step();
    chk({5'h0, cur_mode}, 8'h0, "R9", "back to Normal");
    chk({7'h0, wake_rst}, {7'h0, (m == 5) ? 1'b1 : 1'b0}, "R10", "wakeup reset");
    step();
    chk({7'h0, wake_rst}, 8'h0, "R10", "wakeup reset is one cycle");
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = '0; gen_keep = 1'b0; top_keep = 1'b0;
    step_len = '0; cpu_standby = 1'b0; wake_evt = 1'b0; pwr_good = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk({5'h0, cur_mode}, 8'h0, "R1", "reset cur_mode");
    chk({7'h0, mode_err}, 8'h0, "R1", "reset mode_err");
    chk({2'h0, clk_now(), pwr_now()}, 8'h3F, "R1", "reset clocks and power");
    chk({3'h0, reg_en, iso_now()}, 8'h10, "R1", "reset regulator and isolation");
    // wake in Normal
    wake_evt = 1'b1; step(); wake_evt = 1'b0; step();
    chk({2'h0, clk_now(), pwr_now()}, 8'h3F, "R12", "wake in Normal ignored");
    chk({4'h0, iso_now()}, 8'h0, "R12", "wake in Normal leaves isolation off");
    // directed corners
    for (int m = 0; m < 8; m++) run_mode(m, 1'b0, 1'b0, 0, 2, 1'b0);
    run_mode(2, 1'b1, 1'b0, 1, 0, 1'b0);
    run_mode(4, 1'b0, 1'b1, 2, 3, 1'b0);
    run_mode(5, 1'b0, 1'b0, 1, 1, 1'b1);
    run_mode(3, 1'b0, 1'b0, 3, PGT + 4, 1'b0);
    run_mode(1, 1'b0, 1'b0, 0, PGT - 1, 1'b1);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      run_mode(int'($urandom % 8), 1'($urandom), 1'($urandom),
               int'($urandom % 4), int'($urandom % (PGT + 4)),
               ($urandom % 4) == 0);
      if (($urandom % 3) == 0) begin
        wake_evt = 1'b1; step(); wake_evt = 1'b0; step();
        chk({2'h0, clk_now(), pwr_now()}, 8'h3F, "R12", "random wake in Normal ignored");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule